// File: doc/BRIEF.md
# Battery Charge Sequencer

This block is the digital controller that steps a single-cell battery through its charge cycle. Its inputs are single-bit comparator results that are already synchronized to the clock: input presence, input headroom over the battery, three battery-voltage levels, the recharge level and the end-of-charge current level. It also has a small register port through which software sets the charge setpoints, turns charging on or off and reads back status. Its outputs are the active charge mode, which goes to the analog power stage, and the setpoint codes that the regulation loops use.

Each comparator flag passes through a persistence filter before the state machine sees it, so that comparator chatter cannot cause a phase change. After a valid adaptor appears, the block leaves the off state and starts charging without any software command. Losing the input returns the block to off from any state, and clearing the enable bit puts it in a hold (fault) state.

Top module: `chgseq_top`

## Requirements
- R1: Mode codes are OFF=0, SAFE=1, PRE=2, CC=3, CV=4, DONE=5, FAULT=6. Charging moves SAFE to PRE when `vbat_safe` is 1, and PRE to CC when `vbat_pre` is 1. No other path exists between these phases.
- R2: The input counts as valid only while both filtered `vin_det` and `vin_hdrm` are 1. While the input is invalid, the next mode is OFF from any state.
- R3: From OFF with valid input and enable set, the block enters SAFE with no software action. On every exit from OFF it samples `fet_det` into status bit 3.
- R4: CC moves to CV when filtered `vbat_cv` is 1.
- R5: CV moves to DONE only when filtered `vbat_rechg` is 1 and filtered `ibat_eoc` is 1. Either flag alone leaves the block in CV.
- R6: DONE returns directly to CC when filtered `vbat_rechg` falls to 0.
- R7: While the enable bit (address 0, bit 0, default 1) is 0 and the input is valid, the next mode is FAULT. From FAULT, with enable at 1 and valid input, the next mode is SAFE.
- R8: Address 1 holds the charge-current code in bits [3:0] (default 4), the high-range bit in bit 4 (default 0) and the end-of-charge code in bits [7:5] (default 2). Address 2 holds the charge-voltage code in bits [5:0] (default 20), and bits [7:6] read as 0. A write updates the field outputs on the next clock edge.
- R9: Writing 1 to address 0 bit 1 returns every register to its default on the next edge. That bit always reads 0.
- R10: A comparator flag change reaches the state machine only after the raw value has differed from the filtered value for STABLE_CYC consecutive cycles. A shorter pulse has no effect.
- R11: Address 3 reads the mode in bits [2:0] and the battery-FET bit in bit 3. Writes to address 3 are ignored. The mode changes in the clock cycle after the transition condition is met at the state machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_det | input | 1 | Input voltage above detect level |
| vin_hdrm | input | 1 | Input minus battery above charger-detect level |
| vbat_safe | input | 1 | Battery above safe-charge exit level |
| vbat_pre | input | 1 | Battery above pre-charge exit level |
| vbat_cv | input | 1 | Battery near the programmed charge voltage |
| vbat_rechg | input | 1 | Battery above recharge level |
| ibat_eoc | input | 1 | Charge current below end-of-charge level |
| fet_det | input | 1 | Battery FET detected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| chg_mode | output | 3 | Active charge mode |
| ichg_code | output | 4 | Charge-current code |
| ichg_hi | output | 1 | Charge-current high-range bit |
| ieoc_code | output | 3 | End-of-charge current code |
| vchg_code | output | 6 | Charge-voltage code |

## Verification
The assertions check the following on every cycle: the mode is always a legal code, each phase moves only to its allowed successors, an invalid input forces OFF, a cleared enable forces OFF or FAULT, and register writes and register reset land on the field outputs. The bench scenarios are needed for the timing-dependent behaviour: the exact filter delay, rejection of short pulses, the two-flag end-of-charge condition against each single flag, capture of the battery-FET bit, and the random walks whose final mode is compared against a reference model of the phase rules.

// File: rtl/chgseq_pkg.sv
package chgseq_pkg;
    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,
        MODE_SAFE  = 3'd1,
        MODE_PRE   = 3'd2,
        MODE_CC    = 3'd3,
        MODE_CV    = 3'd4,
        MODE_DONE  = 3'd5,
        MODE_FAULT = 3'd6
    } chg_mode_e;

    localparam int unsigned NFLAG   = 7;
    localparam int unsigned F_VDET  = 0;
    localparam int unsigned F_HDRM  = 1;
    localparam int unsigned F_SAFE  = 2;
    localparam int unsigned F_PRE   = 3;
    localparam int unsigned F_CV    = 4;
    localparam int unsigned F_RECHG = 5;
    localparam int unsigned F_EOC   = 6;

    localparam logic [3:0] ICHG_DEF = 4'd4;
    localparam logic       IHI_DEF  = 1'b0;
    localparam logic [2:0] IEOC_DEF = 3'd2;
    localparam logic [5:0] VCHG_DEF = 6'd20;

    typedef struct packed {
        logic       en;
        logic [3:0] ichg;
        logic       ihi;
        logic [2:0] ieoc;
        logic [5:0] vchg;
    } cfg_t;

    localparam cfg_t CFG_DEF = '{en: 1'b1, ichg: ICHG_DEF, ihi: IHI_DEF,
                                 ieoc: IEOC_DEF, vchg: VCHG_DEF};
endpackage

// File: rtl/chgseq_deb.sv
module chgseq_deb #(
    parameter int unsigned STABLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int unsigned CW = $clog2(STABLE_CYC + 1);

    typedef struct packed {
        logic          filt;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (raw == s_q.filt) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == CW'(STABLE_CYC - 1)) begin
            s_d.filt = raw;
            s_d.cnt  = '0;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign filt = s_q.filt;
endmodule

// File: rtl/chgseq_regs.sv
module chgseq_regs
    import chgseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic [2:0] mode,
    input  logic       fet_bit,
    output logic [7:0] reg_rdata,
    output cfg_t       cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            unique case (reg_addr)
                2'd0: begin
                    if (reg_wdata[1]) cfg_d = CFG_DEF;
                    else              cfg_d.en = reg_wdata[0];
                end
                2'd1: begin
                    cfg_d.ichg = reg_wdata[3:0];
                    cfg_d.ihi  = reg_wdata[4];
                    cfg_d.ieoc = reg_wdata[7:5];
                end
                2'd2:    cfg_d.vchg = reg_wdata[5:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_DEF;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (reg_addr)
            2'd0:    reg_rdata = {7'b0, cfg_q.en};
            2'd1:    reg_rdata = {cfg_q.ieoc, cfg_q.ihi, cfg_q.ichg};
            2'd2:    reg_rdata = {2'b0, cfg_q.vchg};
            default: reg_rdata = {4'b0, fet_bit, mode};
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/chgseq_fsm.sv
module chgseq_fsm
    import chgseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flg,
    input  logic             en,
    input  logic             fet_det,
    output chg_mode_e        mode,
    output logic             fet_bit
);
    typedef struct packed {
        chg_mode_e mode;
        logic      fet;
    } fsm_t;

    fsm_t s_d, s_q;
    logic in_ok;

    assign in_ok = flg[F_VDET] & flg[F_HDRM];

    always_comb begin
        s_d = s_q;
        if (!in_ok) begin
            s_d.mode = MODE_OFF;
        end else if (!en) begin
            s_d.mode = MODE_FAULT;
        end else begin
            unique case (s_q.mode)
                MODE_OFF:   s_d.mode = MODE_SAFE;
                MODE_SAFE:  if (flg[F_SAFE]) s_d.mode = MODE_PRE;
                MODE_PRE:   if (flg[F_PRE])  s_d.mode = MODE_CC;
                MODE_CC:    if (flg[F_CV])   s_d.mode = MODE_CV;
                MODE_CV:    if (flg[F_RECHG] && flg[F_EOC]) s_d.mode = MODE_DONE;
                MODE_DONE:  if (!flg[F_RECHG]) s_d.mode = MODE_CC;
                MODE_FAULT: s_d.mode = MODE_SAFE;
                default:    s_d.mode = MODE_OFF;
            endcase
        end
        if (s_q.mode == MODE_OFF && s_d.mode != MODE_OFF) s_d.fet = fet_det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_OFF, fet: 1'b0};
        else        s_q <= s_d;
    end

    assign mode    = s_q.mode;
    assign fet_bit = s_q.fet;
endmodule

// File: rtl/chgseq_top.sv
module chgseq_top
    import chgseq_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vin_det,
    input  logic       vin_hdrm,
    input  logic       vbat_safe,
    input  logic       vbat_pre,
    input  logic       vbat_cv,
    input  logic       vbat_rechg,
    input  logic       ibat_eoc,
    input  logic       fet_det,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [2:0] chg_mode,
    output logic [3:0] ichg_code,
    output logic       ichg_hi,
    output logic [2:0] ieoc_code,
    output logic [5:0] vchg_code
);
    logic [NFLAG-1:0] raw_flg;
    logic [NFLAG-1:0] flt_flg;
    cfg_t             cfg;
    chg_mode_e        mode;
    logic             fet_bit;
    logic             in_ok;
    logic             chg_en;

    assign raw_flg = {ibat_eoc, vbat_rechg, vbat_cv, vbat_pre, vbat_safe, vin_hdrm, vin_det};

    for (genvar i = 0; i < NFLAG; i++) begin : g_deb
        chgseq_deb #(.STABLE_CYC(STABLE_CYC)) u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_flg[i]),
            .filt (flt_flg[i])
        );
    end

    chgseq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .mode     (mode),
        .fet_bit  (fet_bit),
        .reg_rdata(reg_rdata),
        .cfg      (cfg)
    );

    chgseq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .flg    (flt_flg),
        .en     (cfg.en),
        .fet_det(fet_det),
        .mode   (mode),
        .fet_bit(fet_bit)
    );

    assign in_ok     = flt_flg[F_VDET] & flt_flg[F_HDRM];
    assign chg_en    = cfg.en;
    assign chg_mode  = mode;
    assign ichg_code = cfg.ichg;
    assign ichg_hi   = cfg.ihi;
    assign ieoc_code = cfg.ieoc;
    assign vchg_code = cfg.vchg;
endmodule

// File: rtl/chgseq_chk.sv
module chgseq_chk
    import chgseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] chg_mode,
    input logic       in_ok,
    input logic       chg_en,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [3:0] ichg_code,
    input logic       ichg_hi,
    input logic [2:0] ieoc_code,
    input logic [5:0] vchg_code
);
    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chg_mode <= 3'd6);

    assert_safe_succ_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chg_mode == MODE_SAFE |=> chg_mode inside {MODE_SAFE, MODE_PRE, MODE_OFF, MODE_FAULT});

    assert_pre_succ_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chg_mode == MODE_PRE |=> chg_mode inside {MODE_PRE, MODE_CC, MODE_OFF, MODE_FAULT});

    assert_cc_succ_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chg_mode == MODE_CC |=> chg_mode inside {MODE_CC, MODE_CV, MODE_OFF, MODE_FAULT});

    assert_cv_succ_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_mode == MODE_CV |=> chg_mode inside {MODE_CV, MODE_DONE, MODE_OFF, MODE_FAULT});

    assert_done_succ_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chg_mode == MODE_DONE |=> chg_mode inside {MODE_DONE, MODE_CC, MODE_OFF, MODE_FAULT});

    assert_off_succ_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chg_mode == MODE_OFF |=> chg_mode inside {MODE_OFF, MODE_SAFE, MODE_FAULT});

    assert_fault_succ_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_mode == MODE_FAULT |=> chg_mode inside {MODE_FAULT, MODE_SAFE, MODE_OFF});

    assert_input_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ok |=> chg_mode == MODE_OFF);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en |=> chg_mode inside {MODE_OFF, MODE_FAULT});

    assert_iset_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=>
            {ieoc_code, ichg_hi, ichg_code} == $past(reg_wdata));

    assert_vset_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=> vchg_code == $past(reg_wdata[5:0]));

    assert_reg_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[1]) |=>
            (chg_en && ichg_code == ICHG_DEF && ichg_hi == IHI_DEF &&
             ieoc_code == IEOC_DEF && vchg_code == VCHG_DEF));
endmodule

bind chgseq_top chgseq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chg_mode (chg_mode),
    .in_ok    (in_ok),
    .chg_en   (chg_en),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .ichg_code(ichg_code),
    .ichg_hi  (ichg_hi),
    .ieoc_code(ieoc_code),
    .vchg_code(vchg_code)
);

// File: tb/chgseq_top_bench.sv
module chgseq_top_bench;
    localparam int CLK_PER = 10;
    localparam int STAB    = 4;

    localparam logic [2:0] M_OFF = 3'd0, M_SAFE = 3'd1, M_PRE = 3'd2, M_CC = 3'd3,
                           M_CV = 3'd4, M_DONE = 3'd5, M_FAULT = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin_det = 0, vin_hdrm = 0, vbat_safe = 0, vbat_pre = 0;
    logic vbat_cv = 0, vbat_rechg = 0, ibat_eoc = 0, fet_det = 0;
    logic       reg_wr = 0;
    logic [1:0] reg_addr = 2'd3;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] chg_mode;
    logic [3:0] ichg_code;
    logic       ichg_hi;
    logic [2:0] ieoc_code;
    logic [5:0] vchg_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PER/2) clk = ~clk;

    chgseq_top #(.STABLE_CYC(STAB)) u_chgseq_top (
        .clk(clk), .rst_n(rst_n), .vin_det(vin_det), .vin_hdrm(vin_hdrm),
        .vbat_safe(vbat_safe), .vbat_pre(vbat_pre), .vbat_cv(vbat_cv),
        .vbat_rechg(vbat_rechg), .ibat_eoc(ibat_eoc), .fet_det(fet_det),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .chg_mode(chg_mode), .ichg_code(ichg_code),
        .ichg_hi(ichg_hi), .ieoc_code(ieoc_code), .vchg_code(vchg_code)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 2'd3;
    endtask

    function automatic logic [2:0] step(logic [2:0] s, logic [6:0] f, logic en);
        if (!(f[0] && f[1])) return M_OFF;
        if (!en) return M_FAULT;
        case (s)
            M_OFF:   return M_SAFE;
            M_SAFE:  return f[2] ? M_PRE : M_SAFE;
            M_PRE:   return f[3] ? M_CC : M_PRE;
            M_CC:    return f[4] ? M_CV : M_CC;
            M_CV:    return (f[5] && f[6]) ? M_DONE : M_CV;
            M_DONE:  return f[5] ? M_DONE : M_CC;
            M_FAULT: return M_SAFE;
            default: return M_OFF;
        endcase
    endfunction

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2;
        logic [2:0] em;
        logic       efet, een;
        logic [6:0] fl;
        void'($urandom(32'd31337));

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R11 reset mode", chg_mode, M_OFF);
        rd(2'd1, d); check("R8 iset default", d, 8'h44);
        rd(2'd2, d); check("R8 vset default", d, 8'h14);
        rd(2'd0, d); check("R7 enable default", d, 8'h01);
        rd(2'd3, d); check("R11 status reset", d, 8'h00);

        @(negedge clk); vin_det = 1;
        wait_cyc(STAB + 3);
        check("R2 detect alone stays off", chg_mode, M_OFF);

        @(negedge clk); vin_hdrm = 1; fet_det = 1;
        wait_cyc(STAB);
        check("R11 no early transition", chg_mode, M_OFF);
        wait_cyc(1);
        check("R3 auto start to safe", chg_mode, M_SAFE);
        @(negedge clk); fet_det = 0;
        rd(2'd3, d); check("R3 status fet and mode", d, 8'h09);

        @(negedge clk); vbat_safe = 1;
        repeat (STAB - 1) @(negedge clk);
        vbat_safe = 0;
        wait_cyc(2 * STAB);
        check("R10 short pulse ignored", chg_mode, M_SAFE);

        @(negedge clk); vbat_safe = 1;
        wait_cyc(STAB + 1);
        check("R1 safe to pre", chg_mode, M_PRE);
        @(negedge clk); vbat_pre = 1;
        wait_cyc(STAB + 1);
        check("R1 pre to cc", chg_mode, M_CC);
        @(negedge clk); vbat_cv = 1;
        wait_cyc(STAB + 1);
        check("R4 cc to cv", chg_mode, M_CV);

        @(negedge clk); ibat_eoc = 1;
        wait_cyc(STAB + 3);
        check("R5 eoc alone stays cv", chg_mode, M_CV);
        @(negedge clk); ibat_eoc = 0; vbat_rechg = 1;
        wait_cyc(STAB + 3);
        check("R5 rechg alone stays cv", chg_mode, M_CV);
        @(negedge clk); ibat_eoc = 1;
        wait_cyc(STAB + 1);
        check("R5 both flags to done", chg_mode, M_DONE);

        @(negedge clk); vbat_rechg = 0;
        wait_cyc(STAB + 1);
        check("R6 recharge to cc", chg_mode, M_CC);
        wait_cyc(1);
        check("R4 cc back to cv", chg_mode, M_CV);

        wr(2'd0, 8'h00);
        wait_cyc(1);
        check("R7 disable to fault", chg_mode, M_FAULT);
        rd(2'd0, d); check("R7 enable reads 0", d, 8'h00);
        wait_cyc(3);
        check("R7 fault holds", chg_mode, M_FAULT);
        wr(2'd0, 8'h01);
        wait_cyc(1);
        check("R7 fault exit to safe", chg_mode, M_SAFE);

        wr(2'd1, 8'hB7);
        check("R8 ichg", ichg_code, 4'd7);
        check("R8 ihi", ichg_hi, 1'b1);
        check("R8 ieoc", ieoc_code, 3'd5);
        wr(2'd2, 8'hFF);
        check("R8 vchg", vchg_code, 6'h3F);
        rd(2'd2, d); check("R8 vset upper bits zero", d, 8'h3F);
        rd(2'd3, d);
        wr(2'd3, 8'hF0);
        rd(2'd3, d2); check("R11 status write ignored", d2, d);

        wr(2'd0, 8'h02);
        check("R9 ichg default", ichg_code, 4'd4);
        check("R9 vchg default", vchg_code, 6'd20);
        rd(2'd1, d); check("R9 iset default", d, 8'h44);
        rd(2'd0, d); check("R9 reset bit self clears", d, 8'h01);

        @(negedge clk); vin_hdrm = 0;
        wait_cyc(STAB + 1);
        check("R2 input loss to off", chg_mode, M_OFF);

        em = M_OFF; efet = 1'b1; een = 1'b1;
        fl = {ibat_eoc, vbat_rechg, vbat_cv, vbat_pre, vbat_safe, vin_hdrm, vin_det};
        for (int it = 0; it < 80; it++) begin
            if (($urandom % 4) == 0) begin
                een = ($urandom % 5) != 0;
                wr(2'd0, {7'b0, een});
                wait_cyc(STAB + 10);
                for (int k = 0; k < 8; k++) begin
                    logic [2:0] nx;
                    nx = step(em, fl, een);
                    if (em == M_OFF && nx != M_OFF) efet = fet_det;
                    em = nx;
                end
                check("R7 random enable change", chg_mode, em);
            end
            @(negedge clk);
            fl = 7'($urandom);
            if (($urandom % 10) < 8) fl[1:0] = 2'b11;
            {ibat_eoc, vbat_rechg, vbat_cv, vbat_pre, vbat_safe, vin_hdrm, vin_det} = fl;
            fet_det = 1'($urandom);
            wait_cyc(STAB + 10);
            for (int k = 0; k < 8; k++) begin
                logic [2:0] nx;
                nx = step(em, fl, een);
                if (em == M_OFF && nx != M_OFF) efet = fet_det;
                em = nx;
            end
            check("R1 R4 R5 R6 random mode", chg_mode, em);
            rd(2'd3, d);
            check("R11 R3 random status", d, {4'b0, efet, em});
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule